// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a synthesizer's input clock by a programmable ratio and emits one single-cycle pulse per division period toward a phase/frequency detector. A dual-modulus prescaler, built from a synchronous divide-by-4/5 core plus a short extension counter, divides by either P or P+1. A swallow counter holds the prescaler at P+1 for the first A prescaler periods. A main counter then ends the period after B prescaler periods in total. The overall ratio is therefore N = B·P + A, where P is the lower modulus.

One select bit picks the modulus pair: 0 gives 8/9 and 1 gives 16/17. The select bit and the A and B values are sampled only at a reload, which is either the synchronous reset or the end of a division period. A period that is already running therefore never changes length. A configuration is invalid when B is less than A or less than 3. While such a configuration is in effect the block raises an error flag and keeps its output pulse low.

Top module: `swallow_fbdiv`

## Requirements
- R1: With select bit 0 (P = 8), successive output pulses are exactly B·8 + A input clocks apart.
- R2: With select bit 1 (P = 16), successive output pulses are exactly B·16 + A input clocks apart.
- R3: The output pulse is high for exactly one input clock, and no pulse appears at any other time.
- R4: After the last clock edge with reset high, the first pulse is visible after the N-th following rising edge.
- R5: If B < A or B < 3 at a reload, `cfg_bad` is high and `div_pulse` stays low for the whole period that follows.
- R6: A change of the select bit, A or B in the middle of a period does not alter that period. The new values set the length of the next period.
- R7: During reset `div_pulse` is low and `cfg_bad` shows the validity of the values present at the reset edge (1 means invalid).
- R8: The boundary cases A = 0 (every prescaler period is P) and A = B (every prescaler period is P+1) both give N = B·P + A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high; also reloads the configuration |
| mod_sel | input | 1 | Modulus pair select: 0 = 8/9, 1 = 16/17 |
| a_val | input | A_W (6) | Swallow count A |
| b_val | input | B_W (11) | Main count B |
| div_pulse | output | 1 | One-clock divided output pulse |
| cfg_bad | output | 1 | High while the loaded configuration is invalid |

## Verification
The divider is run with mid-range A and B under each modulus pair. This separates the two values of P and catches a swapped or miscounted swallow phase. A = 0 and A = B are run to expose a swallow counter that is off by one at either extreme, and the smallest legal B = 3 is used for the shortest period. A configuration change in the middle of a period checks that the running period keeps its old length and the next period takes the new one. Settings with B below A and B below 3 confirm that the error flag is raised and no pulse escapes.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

  // Divide ratio of the 4/5 core in its normal state.
  localparam int unsigned CORE_DIV = 4;

  // Lower modulus of a pair: the core repeated 2**stages times.
  function automatic int unsigned pre_div(int unsigned stages);
    return CORE_DIV << stages;
  endfunction

  // Legal programming: B at least A and at least 3.
  function automatic logic cfg_ok(int unsigned a, int unsigned b);
    return (b >= a) && (b >= 32'd3);
  endfunction

  // Total ratio of one division period.
  function automatic int unsigned fb_ratio(int unsigned a, int unsigned b,
                                           int unsigned p);
    return b * p + a;
  endfunction

endpackage

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler #(
  parameter int unsigned EXT_LO = 1,
  parameter int unsigned EXT_HI = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic swallow,
  output logic pre_done
);
  localparam int unsigned EXT_W = (EXT_HI > EXT_LO) ? EXT_HI : EXT_LO;
  localparam int unsigned XW    = (EXT_W == 0) ? 1 : EXT_W;
  localparam logic [XW-1:0] LO_MAX = XW'((1 << EXT_LO) - 1);
  localparam logic [XW-1:0] HI_MAX = XW'((1 << EXT_HI) - 1);

  logic [2:0]    core_q;
  logic [XW-1:0] ext_q;
  logic [XW-1:0] ext_max;
  logic          ext_last;
  logic [2:0]    core_last;
  logic          core_wrap;

  assign ext_max   = sel ? HI_MAX : LO_MAX;
  assign ext_last  = (ext_q == ext_max);
  // The core runs as divide-by-5 on the last pass only while swallowing.
  assign core_last = (swallow && ext_last) ? 3'd4 : 3'd3;
  assign core_wrap = (core_q == core_last);
  assign pre_done  = core_wrap && ext_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_q <= '0;
      ext_q  <= '0;
    end else if (core_wrap) begin
      core_q <= '0;
      ext_q  <= ext_last ? '0 : ext_q + 1'b1;
    end else begin
      core_q <= core_q + 3'd1;
    end
  end

  assert_core_range_R1: assert property (@(posedge clk) disable iff (rst)
    core_q <= 3'd4);
  assert_ext_range_R2: assert property (@(posedge clk) disable iff (rst)
    ext_q <= ext_max);
  assert_fifth_state_R8: assert property (@(posedge clk) disable iff (rst)
    (core_q == 3'd4) |-> (swallow && ext_last));

endmodule

// File: rtl/fbdiv_swallow_ctr.sv
module fbdiv_swallow_ctr #(
  parameter int unsigned A_W = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [A_W-1:0] a_in,
  output logic           swallow
);
  logic [A_W-1:0] a_q;

  assign swallow = (a_q != '0);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      a_q <= a_in;
    end else if (step && swallow) begin
      a_q <= a_q - 1'b1;
    end
  end

  assert_a_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(a_q));
  assert_a_floor_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && !swallow) |=> !swallow);

endmodule

// File: rtl/fbdiv_main_ctr.sv
module fbdiv_main_ctr #(
  parameter int unsigned B_W = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic [B_W-1:0] b_in,
  output logic           terminal
);
  logic [B_W-1:0] b_q;

  // Terminal count on the last prescaler period; also covers B = 0 or 1.
  assign terminal = step && (b_q <= B_W'(1));

  always_ff @(posedge clk) begin
    if (rst || terminal) begin
      b_q <= b_in;
    end else if (step) begin
      b_q <= b_q - 1'b1;
    end
  end

  assert_b_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(b_q));

endmodule

// File: rtl/swallow_fbdiv.sv
module swallow_fbdiv #(
  parameter int unsigned A_W    = 6,
  parameter int unsigned B_W    = 11,
  parameter int unsigned EXT_LO = 1,
  parameter int unsigned EXT_HI = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mod_sel,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  output logic           div_pulse,
  output logic           cfg_bad
);
  import fbdiv_pkg::*;

  localparam int unsigned PER_W = B_W + EXT_HI + 4;
  localparam int unsigned P_LO  = pre_div(EXT_LO);
  localparam int unsigned P_HI  = pre_div(EXT_HI);

  logic           sel_q;
  logic [A_W-1:0] a_sh;
  logic [B_W-1:0] b_sh;
  logic           bad_q;
  logic           pulse_q;
  logic           pre_done;
  logic           swallow;
  logic           reload;
  logic [PER_W-1:0] period_cnt;

  // Configuration is captured only at a reload.
  always_ff @(posedge clk) begin
    if (rst || reload) begin
      sel_q <= mod_sel;
      a_sh  <= a_val;
      b_sh  <= b_val;
      bad_q <= !cfg_ok(32'(a_val), 32'(b_val));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= reload && !bad_q;
    end
  end

  // Cycle count inside the current period, observed by the assertions.
  always_ff @(posedge clk) begin
    if (rst || reload) begin
      period_cnt <= '0;
    end else begin
      period_cnt <= period_cnt + 1'b1;
    end
  end

  fbdiv_prescaler #(.EXT_LO(EXT_LO), .EXT_HI(EXT_HI)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel_q),
    .swallow  (swallow),
    .pre_done (pre_done)
  );

  fbdiv_swallow_ctr #(.A_W(A_W)) u_swal (
    .clk     (clk),
    .rst     (rst),
    .load    (reload),
    .step    (pre_done),
    .a_in    (a_val),
    .swallow (swallow)
  );

  fbdiv_main_ctr #(.B_W(B_W)) u_main (
    .clk      (clk),
    .rst      (rst),
    .step     (pre_done),
    .b_in     (b_val),
    .terminal (reload)
  );

  assign div_pulse = pulse_q;
  assign cfg_bad   = bad_q;

  assert_period_len_R1: assert property (@(posedge clk) disable iff (rst)
    (reload && !bad_q) |->
      (32'(period_cnt) + 32'd1 ==
       fb_ratio(32'(a_sh), 32'(b_sh), sel_q ? P_HI : P_LO)));
  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);
  assert_bad_silent_R5: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> !$past(bad_q));
  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !reload |=> ($stable(sel_q) && $stable(a_sh) && $stable(b_sh)));

endmodule

// File: tb/swallow_fbdiv_tb_top.sv
module swallow_fbdiv_tb_top;
  localparam int A_W = 6;
  localparam int B_W = 11;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst = 1'b1;
  logic           mod_sel = 1'b0;
  logic [A_W-1:0] a_val = '0;
  logic [B_W-1:0] b_val = B_W'(3);
  logic           div_pulse;
  logic           cfg_bad;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int pulses_seen = 0;
  bit prev_pulse = 1'b0;
  bit done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  swallow_fbdiv dut_i (
    .clk(clk), .rst(rst), .mod_sel(mod_sel), .a_val(a_val), .b_val(b_val),
    .div_pulse(div_pulse), .cfg_bad(cfg_bad)
  );

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  function automatic int model_n(bit sel, int a, int b);
    int p;
    p = sel ? 16 : 8;
    return a + p * b;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  // Monitor: pops expected pulse times and compares.
  always @(negedge clk) begin
    if (!rst) begin
      if (div_pulse) begin
        pulses_seen++;
        if (exp_q.size() == 0) check(1'b0, "R3 unexpected pulse", cyc, -1);
        else begin
          automatic int e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(cyc == e, t, cyc, e);
        end
        if (prev_pulse) check(1'b0, "R3 pulse width", 2, 1);
      end
      while (exp_q.size() > 0 && exp_q[0] < cyc) begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(1'b0, {t, " missing pulse"}, cyc, e);
      end
      prev_pulse = div_pulse;
    end else begin
      prev_pulse = 1'b0;
    end
  end

  // Reset and load a configuration; checks the reset state (R7).
  task automatic start(bit sel, int a, int b);
    @(posedge clk); #5;
    rst = 1'b1; mod_sel = sel; a_val = A_W'(a); b_val = B_W'(b);
    @(posedge clk); #5;
    check(div_pulse == 1'b0, "R7 pulse low in reset", int'(div_pulse), 0);
    check(cfg_bad == !(b >= a && b >= 3), "R7 cfg_bad at reset",
          int'(cfg_bad), int'(!(b >= a && b >= 3)));
    pulses_seen = 0;
    rst = 1'b0;
  endtask

  task automatic run(bit sel, int a, int b, int np, string tag);
    int n;
    n = model_n(sel, a, b);
    start(sel, a, b);
    for (int k = 1; k <= np; k++) begin
      exp_q.push_back(k * n);
      tag_q.push_back(k == 1 ? {tag, " R4 first pulse"} : tag);
    end
    repeat (np * n + 3) @(posedge clk);
    #5;
    check(pulses_seen == np, {tag, " R3 pulse count"}, pulses_seen, np);
  endtask

  task automatic run_bad(int a, int b);
    start(1'b0, a, b);
    repeat (300) @(posedge clk);
    #5;
    check(pulses_seen == 0, "R5 no pulse while invalid", pulses_seen, 0);
    check(cfg_bad == 1'b1, "R5 cfg_bad held", int'(cfg_bad), 1);
  endtask

  initial begin
    run(1'b0, 3, 10, 3, "R1 P=8");
    run(1'b0, 63, 63, 2, "R1 P=8 wide A");
    run(1'b1, 5, 6, 3, "R2 P=16");
    run(1'b0, 0, 3, 3, "R8 A=0 min B");
    run(1'b1, 7, 7, 2, "R8 A=B");
    run_bad(5, 3);
    run_bad(0, 2);
    // R6: change mid-period; periods 34 then 81.
    start(1'b0, 2, 4);
    exp_q.push_back(34);  tag_q.push_back("R6 old period");
    exp_q.push_back(115); tag_q.push_back("R6 new period");
    exp_q.push_back(196); tag_q.push_back("R6 new period");
    repeat (10) @(posedge clk);
    #5;
    mod_sel = 1'b1; a_val = A_W'(1); b_val = B_W'(5);
    repeat (200) @(posedge clk);
    #5;
    check(pulses_seen == 3, "R6 pulse count", pulses_seen, 3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule